// File: doc/BRIEF.md
# Triple Interval Timer Peripheral

This peripheral holds three independent 16-bit down-counters behind a byte-wide synchronous register bus. Each counter has a reload value. On every enabled tick the count drops by one. When the count would reach zero, it reloads from its reload value in that same step. If that counter's interrupt enable is set, the step also raises the counter's pending flag. The three flags are ORed onto a single interrupt line. Software clears a flag by reading the low count byte of that counter.

Counting for all three counters is governed by a two-state run controller: `ST_HOLD` (the reset state) and `ST_RUN`. The `START` transition, from `ST_HOLD` to `ST_RUN`, is a write to the primary control register with bit 0 clear. The `STOP` transition, from `ST_RUN` to `ST_HOLD`, is the same write with bit 0 set. The primary and tertiary control registers share offset 0. A select bit, written at offset 1, decides which of the two receives a write to offset 0. The three interrupt enables are spread across the three control registers.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset the counts and reload values are 32, 3200 and 801 for counters 1, 2 and 3. All enables and flags are clear, `irq_o` is low, and the controller is in `ST_HOLD`.
- R2: A write to offset 1 stores data bit 0 as the select bit and data bit 6 as the enable of counter 2. A write to offset 0 with select = 1 sets the enable of counter 1 from bit 6. With select = 0 it sets the enable of counter 3 from bit 6 and has no effect on counting.
- R3: In `ST_HOLD`, ticks leave all counts unchanged. With select = 1, writing bit 0 = 0 at offset 0 takes `START`. Writing bit 0 = 1 takes `STOP`.
- R4: In `ST_RUN`, each cycle with `tick_i` high lowers every count by one, wrapping modulo 2^16. Cycles without `tick_i` change no count.
- R5: A tick that takes a count from 1 toward 0 loads that counter's reload value instead. A reload value L therefore produces one reload every L ticks.
- R6: A reload raises the counter's flag only if that counter's enable is set. A read of offset 1 returns the flags of counters 1, 2 and 3 in bits 0, 1 and 2, with bits 7..3 zero.
- R7: A read of offset 3, 5 or 7 clears only the flag of counter 1, 2 or 3. If the read and a reload of the same counter fall in one cycle, the clear wins.
- R8: Offsets 2, 4 and 6 (high byte) and 3, 5 and 7 (low byte) read back the current count of counters 1, 2 and 3. A high-byte write is buffered, and the next low-byte write sets the reload value to {buffer, data}. A read of offset 0 returns zero.
- R9: `irq_o` is high exactly while at least one flag is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | OR of the three pending flags |

## Verification
Read data is combinational, so the bench samples `rdata_o` in the cycle of the strobe, just after driving it. A clear caused by that read appears only after the following edge. Writes, ticks, reloads and flag changes all take effect at the first rising edge after the stimulus. The bench drives every stimulus at a falling edge and compares at the next falling edge against a reference model, which it advances arithmetically at that same point. In the read-plus-tick case, the returned byte is the count from before the edge, and the flag that the model expects afterwards is already cleared.

// File: rtl/tit_pkg.sv
package tit_pkg;
    localparam int NUM_TMR = 3;
    localparam int ADDR_W  = 3;

    // fixed offsets of the shared control port and of control 2 / status
    localparam logic [ADDR_W-1:0] OFF_CTL_SHARED = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_CTL_STATUS = 3'd1;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // counter t (0-based) owns a high byte at 2+2t and a low byte at 3+2t
    function automatic logic [ADDR_W-1:0] hi_off(input int t);
        return ADDR_W'(2 + 2 * t);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_off(input int t);
        return ADDR_W'(3 + 2 * t);
    endfunction
endpackage

// File: rtl/tit_run_ctl.sv
module tit_run_ctl
    import tit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic stop_req_i,
    output logic run_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (start_req_i) state_d = ST_RUN;
            ST_RUN:  if (stop_req_i)  state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tit_channel.sv
module tit_channel #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             ie_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lat_o,
    output logic             flag_o
);
    logic [CNT_W-1:0] dec;
    logic             zero_evt;

    assign dec      = cnt_o - CNT_W'(1);
    assign zero_evt = adv_i && (dec == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o  <= RST_VAL;
            lat_o  <= RST_VAL;
            flag_o <= 1'b0;
        end else begin
            if (ld_i)  lat_o <= ld_val_i;
            if (adv_i) cnt_o <= zero_evt ? lat_o : dec;
            // a clearing read outranks a reload in the same cycle
            if (clr_i)                  flag_o <= 1'b0;
            else if (zero_evt && ie_i)  flag_o <= 1'b1;
        end
    end
endmodule

// File: rtl/tit_regs.sv
module tit_regs
    import tit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NT     = 3,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_i,
    input  logic                       rd_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [NT-1:0]              flags_i,
    input  logic [NT-1:0][CNT_W-1:0]   cnt_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       sel_o,
    output logic [NT-1:0]              ie_o,
    output logic                       start_o,
    output logic                       stop_o,
    output logic [NT-1:0]              ld_o,
    output logic [NT-1:0][CNT_W-1:0]   ld_val_o,
    output logic [NT-1:0]              clr_o
);
    logic wr_en, rd_en, wr_shared, wr_ctl2;
    logic [NT-1:0][DATA_W-1:0] hi_q;

    assign wr_en     = cs_i && wr_i;
    assign rd_en     = cs_i && rd_i;
    assign wr_shared = wr_en && (addr_i == OFF_CTL_SHARED);
    assign wr_ctl2   = wr_en && (addr_i == OFF_CTL_STATUS);

    assign start_o = wr_shared && sel_o && !wdata_i[0];
    assign stop_o  = wr_shared && sel_o &&  wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o <= 1'b0;
            ie_o  <= '0;
        end else begin
            if (wr_ctl2) begin
                sel_o   <= wdata_i[0];
                ie_o[1] <= wdata_i[6];
            end
            if (wr_shared) begin
                if (sel_o) ie_o[0]    <= wdata_i[6];
                else       ie_o[NT-1] <= wdata_i[6];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (wr_en && (addr_i == hi_off(t))) hi_q[t] <= wdata_i;
            end
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        assign ld_o[g]     = wr_en && (addr_i == lo_off(g));
        assign clr_o[g]    = rd_en && (addr_i == lo_off(g));
        assign ld_val_o[g] = {hi_q[g], wdata_i};
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (addr_i == OFF_CTL_STATUS) rdata_o = DATA_W'(flags_i);
            for (int t = 0; t < NT; t++) begin
                if (addr_i == hi_off(t)) rdata_o = cnt_i[t][CNT_W-1:DATA_W];
                if (addr_i == lo_off(t)) rdata_o = cnt_i[t][DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RST_T1 = 32,
    parameter int RST_T2 = 3200,
    parameter int RST_T3 = 801
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [NUM_TMR-1:0][CNT_W-1:0] RST_TBL =
        {CNT_W'(RST_T3), CNT_W'(RST_T2), CNT_W'(RST_T1)};

    logic                          run, sel, start_req, stop_req;
    logic [NUM_TMR-1:0]            ie, flags, ld, clr;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt, lat, ld_val;

    tit_run_ctl u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .stop_req_i  (stop_req),
        .run_o       (run)
    );

    tit_regs #(.DATA_W(DATA_W), .NT(NUM_TMR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_i),
        .rd_i     (rd_i),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .flags_i  (flags),
        .cnt_i    (cnt),
        .rdata_o  (rdata_o),
        .sel_o    (sel),
        .ie_o     (ie),
        .start_o  (start_req),
        .stop_o   (stop_req),
        .ld_o     (ld),
        .ld_val_o (ld_val),
        .clr_o    (clr)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        tit_channel #(.CNT_W(CNT_W), .RST_VAL(RST_TBL[g])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_i    (run && tick_i),
            .ld_i     (ld[g]),
            .ld_val_i (ld_val[g]),
            .ie_i     (ie[g]),
            .clr_i    (clr[g]),
            .cnt_o    (cnt[g]),
            .lat_o    (lat[g]),
            .flag_o   (flags[g])
        );
    end

    assign irq_o = |flags;
endmodule

// File: rtl/tit_checker.sv
module tit_checker
    import tit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           tick_i,
    input logic                           cs_i,
    input logic                           rd_i,
    input logic                           wr_i,
    input logic [2:0]                     addr_i,
    input logic [7:0]                     wdata_i,
    input logic                           irq_o,
    input logic                           run,
    input logic                           sel,
    input logic [NUM_TMR-1:0]             ie,
    input logic [NUM_TMR-1:0]             flags,
    input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt,
    input logic [NUM_TMR-1:0][CNT_W-1:0]  lat
);
    // R1
    post_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && !run));

    // R2
    select_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && wr_i && addr_i == OFF_CTL_STATUS) |=> (sel == $past(wdata_i[0])));

    // R3
    frozen_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick_i) |=> (cnt == $past(cnt)));

    // R9
    irq_drop_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(cs_i && rd_i));

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        // R4
        step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick_i && cnt[t] != CNT_W'(1)) |=> (cnt[t] == $past(cnt[t]) - CNT_W'(1)));

        // R5
        reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick_i && cnt[t] == CNT_W'(1)) |=> (cnt[t] == $past(lat[t])));

        // R6
        flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[t]) |-> $past(ie[t]));

        // R7
        read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_i && rd_i && addr_i == lo_off(t)) |=> !flags[t]);
    end
endmodule

bind tri_interval_timer tit_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .cs_i    (cs_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_o   (irq_o),
    .run     (run),
    .sel     (sel),
    .ie      (ie),
    .flags   (flags),
    .cnt     (cnt),
    .lat     (lat)
);

// File: tb/tri_interval_timer_test.sv
module tri_interval_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int nchk = 0, nerr = 0;
    bit done = 0;

    int       m_cnt[3], m_lat[3];
    bit       m_flag[3], m_ie[3];
    bit       m_run = 0, m_sel = 0;
    int       m_hi[3];

    always #10 clk = ~clk;

    tri_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cs_i(cs_i), .rd_i(rd_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_tick();
        if (m_run) begin
            for (int t = 0; t < 3; t++) begin
                int nxt = (m_cnt[t] - 1) & 16'hFFFF;
                if (nxt == 0) begin
                    m_cnt[t] = m_lat[t];
                    if (m_ie[t]) m_flag[t] = 1;
                end else m_cnt[t] = nxt;
            end
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 0) return 0;
        if (a == 1) return {m_flag[2], m_flag[1], m_flag[0]};
        if (a % 2 == 1) return m_cnt[(a - 3) / 2] & 8'hFF;
        return (m_cnt[(a - 2) / 2] >> 8) & 8'hFF;
    endfunction

    function automatic int model_irq();
        return (m_flag[0] || m_flag[1] || m_flag[2]) ? 1 : 0;
    endfunction

    task automatic bus_wr(input int a, input int d);
        cs_i = 1; wr_i = 1; addr_i = 3'(a); wdata_i = 8'(d);
        @(posedge clk);
        @(negedge clk);
        cs_i = 0; wr_i = 0;
        if (a == 1) begin
            m_sel = d[0]; m_ie[1] = d[6];
        end else if (a == 0) begin
            if (m_sel) begin
                m_ie[0] = d[6];
                m_run = !d[0];
            end else m_ie[2] = d[6];
        end else if (a % 2 == 0) m_hi[(a - 2) / 2] = d & 8'hFF;
        else m_lat[(a - 3) / 2] = (m_hi[(a - 3) / 2] << 8) | (d & 8'hFF);
    endtask

    task automatic bus_rd(input string req, input int a, input bit with_tick);
        int exp = model_read(a);
        cs_i = 1; rd_i = 1; addr_i = 3'(a); tick_i = with_tick;
        #1;
        check(req, int'(rdata_o), exp);
        @(posedge clk);
        @(negedge clk);
        cs_i = 0; rd_i = 0; tick_i = 0;
        if (with_tick) model_tick();
        if (a >= 3 && a % 2 == 1) m_flag[(a - 3) / 2] = 0;
    endtask

    task automatic do_tick();
        tick_i = 1;
        @(posedge clk);
        @(negedge clk);
        tick_i = 0;
        model_tick();
        check("R9 irq", int'(irq_o), model_irq());
    endtask

    task automatic check_all(input string req);
        bus_rd({req, " status"}, 1, 0);
        for (int t = 0; t < 3; t++) begin
            bus_rd({req, " count hi"}, 2 + 2 * t, 0);
            bus_rd({req, " count lo"}, 3 + 2 * t, 0);
        end
        check({req, " irq"}, int'(irq_o), model_irq());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        m_cnt = '{32, 3200, 801};
        m_lat = '{32, 3200, 801};
        m_flag = '{0, 0, 0};
        m_ie = '{0, 0, 0};
        m_hi = '{0, 0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state, R8 offset 0 reads zero
        check("R1 irq", int'(irq_o), 0);
        check_all("R1");
        bus_rd("R8 offset0", 0, 0);

        // R3 ticks while held change nothing
        for (int i = 0; i < 5; i++) do_tick();
        check_all("R3 held");

        // R8 reload values via high then low bytes
        bus_wr(2, 0); bus_wr(3, 3);
        bus_wr(4, 0); bus_wr(5, 5);
        bus_wr(6, 0); bus_wr(7, 7);

        // R2 enables through the shared offset, then R3 START
        bus_wr(1, 8'h00);
        bus_wr(0, 8'h40);
        bus_wr(1, 8'h41);
        bus_wr(0, 8'h40);

        // R4/R5/R6 long run through every initial count
        for (int i = 0; i < 3300; i++) begin
            do_tick();
            bus_rd("R6 status", 1, 0);
            if (i % 40 == 39) check_all("R5");
        end

        // R4 no tick, no change
        repeat (3) @(negedge clk);
        check_all("R4 idle");

        // R5/R8 sweep of reload values
        for (int l = 1; l <= 6; l++) begin
            for (int t = 0; t < 3; t++) begin
                bus_wr(2 + 2 * t, 0);
                bus_wr(3 + 2 * t, l + t);
            end
            for (int i = 0; i < 40; i++) begin
                do_tick();
                bus_rd("R6 sweep status", 1, 0);
                if (i % 10 == 9) check_all("R5 sweep");
            end
        end

        // R8 a high byte above zero
        bus_wr(2, 1); bus_wr(3, 2);
        for (int i = 0; i < 300; i++) begin
            do_tick();
            if (i % 25 == 0) check_all("R8 wide");
        end

        // R7 clear beats a simultaneous reload
        for (int i = 0; i < 400 && m_cnt[0] != 1; i++) do_tick();
        check("R7 setup", m_cnt[0], 1);
        bus_rd("R7 read with reload", 3, 1);
        bus_rd("R7 status after clash", 1, 0);
        check("R7 irq", int'(irq_o), model_irq());
        check_all("R7");

        // R6 enables off: reloads raise nothing
        bus_wr(1, 8'h01); bus_wr(0, 8'h00);
        bus_wr(1, 8'h00); bus_wr(0, 8'h00);
        check_all("R6 clear");
        for (int i = 0; i < 30; i++) do_tick();
        check_all("R6 disabled");

        // R3 STOP
        bus_wr(1, 8'h01); bus_wr(0, 8'h01);
        for (int i = 0; i < 10; i++) do_tick();
        check_all("R3 stopped");

        finish_run();
    end
endmodule